// File: doc/BRIEF.md
# Critical Section Offload Queue

This block sits between a group of small cores and one large core in an asymmetric multicore. When a small core reaches a critical section, it does not take the lock itself. It posts a call request carrying four things: the lock address, the program counter where the critical section starts, its stack pointer and, implied by the port it uses, its own core number. The core then stalls. The queue keeps every pending request and offers them one at a time to the large core. The large core runs each critical section and then signals completion. The queue sends that completion back as a one-cycle pulse on the done line of the core that made the request, and that core resumes.

Each core can have at most one request outstanding, so each core owns one storage slot, indexed by its core number. An age matrix records the order in which the slots filled, and dispatch always picks the oldest waiting slot. Only one critical section is in service at a time. If a core posts a second request while its first is still pending or in service, the second request is dropped and an error pulse is raised for that core.

Top module: `csq_request_buffer`

## Requirements
- R1: In the first cycle after reset is released, the queue is empty and nothing is in service: `disp_valid`, `core_done` and `dup_err` are all zero, and `done_ready` is low.
- R2: The lock address, target PC and stack pointer presented on `req_lock`, `req_pc` and `req_sp` in the accepting cycle appear unchanged on `disp_lock`, `disp_pc` and `disp_sp` when that request is offered. `disp_core` gives the index of the requesting core.
- R3: Requests are offered to the large core in the order in which they were accepted.
- R4: Requests accepted in the same cycle are ordered by core index, with the lowest index first.
- R5: At most one request is in service at a time. `disp_valid` is low from the cycle after a dispatch handshake (`disp_valid` and `disp_ready` both high) until the cycle after the matching completion handshake (`done_valid` and `done_ready` both high).
- R6: One cycle after a completion handshake, bit k of `core_done` is high for exactly one cycle, where k is the index of the core whose request was in service. All other bits stay low.
- R7: While nothing is in service, `done_ready` is low, and `done_valid` produces no `core_done` pulse.
- R8: A request from a core whose previous request is still pending or in service is dropped. One cycle later, bit k of `dup_err` pulses for that core k, and the queue contents and the dispatch order do not change.
- R9: `req_ready` is high for every core at all times. While `disp_valid` is high and `disp_ready` is low, the offer stays up, and its core index and fields hold steady.
- R10: A core may post a new request in the same cycle in which its `core_done` pulse is visible, and that request is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NC | Call request strobe, one bit per small core |
| req_ready | output | NC | Request taken, one bit per core (always high) |
| req_lock | input | NC*LOCK_W | Lock address for each core; core k uses slice k |
| req_pc | input | NC*PC_W | Critical section target PC for each core |
| req_sp | input | NC*SP_W | Stack pointer for each core |
| disp_valid | output | 1 | A request is offered to the large core |
| disp_ready | input | 1 | The large core takes the offered request |
| disp_lock | output | LOCK_W | Lock address of the offered request |
| disp_pc | output | PC_W | Target PC of the offered request |
| disp_sp | output | SP_W | Stack pointer of the offered request |
| disp_core | output | $clog2(NC) | Index of the requesting core |
| done_valid | input | 1 | The large core finished the critical section in service |
| done_ready | output | 1 | High while a request is in service |
| core_done | output | NC | One-cycle completion pulse to the requesting core |
| dup_err | output | NC | One-cycle pulse when a core's duplicate request is dropped |

## Verification
The bench first sends requests from all cores in the same cycle. A queue that ignored core index on ties would offer a higher core first. It then sends a duplicate request while the first one is still waiting. A design that accepted the duplicate would dispatch the same core twice, or would overwrite the stored fields. A completion that arrives while nothing is in service checks that a careless design does not pulse a stale `core_done` bit. A request sent in the very cycle its core sees the done pulse catches a slot that frees one cycle too late. Random traffic with stalls on `disp_ready` exercises mixed arrival order and held offers against a reference queue kept in the bench.

// File: rtl/csq_pkg.sv
// Shared definitions for the critical section offload queue.
// Assumes: nothing beyond standard SystemVerilog.
package csq_pkg;

    // Life cycle of the single slot that each requesting core owns.
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,   // no request outstanding
        SLOT_WAIT  = 2'd1,   // request stored, not yet dispatched
        SLOT_SERVE = 2'd2    // request running on the large core
    } slot_state_e;

endpackage

// File: rtl/csq_slot_file.sv
// One request slot per small core.
// What it does: takes in requests, flags duplicates, stores the request
// fields and tracks each slot through idle, waiting and in service.
// Assumes: dispatch_vec and release_vec are one-hot or zero, dispatch_vec
// only selects waiting slots and release_vec only selects the slot in service.
module csq_slot_file
    import csq_pkg::*;
#(
    parameter int NC     = 4,
    parameter int LOCK_W = 16,
    parameter int PC_W   = 16,
    parameter int SP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NC-1:0]      req_valid,
    input  logic [NC*LOCK_W-1:0] req_lock,
    input  logic [NC*PC_W-1:0]   req_pc,
    input  logic [NC*SP_W-1:0]   req_sp,
    input  logic [NC-1:0]      dispatch_vec,
    input  logic [NC-1:0]      release_vec,
    output logic [NC-1:0]      arrive,
    output logic [NC-1:0]      waiting,
    output logic [NC-1:0]      dup_err,
    output logic [NC*LOCK_W-1:0] slot_lock,
    output logic [NC*PC_W-1:0]   slot_pc,
    output logic [NC*SP_W-1:0]   slot_sp
);

    for (genvar k = 0; k < NC; k++) begin : g_slot
        slot_state_e        state_q;
        logic               dup_now;
        logic [LOCK_W-1:0]  lock_q;
        logic [PC_W-1:0]    pc_q;
        logic [SP_W-1:0]    sp_q;

        // Accept a request only when the slot is free; otherwise it is a duplicate.
        always_comb begin
            arrive[k]  = req_valid[k] && (state_q == SLOT_IDLE);
            dup_now    = req_valid[k] && (state_q != SLOT_IDLE);
            waiting[k] = (state_q == SLOT_WAIT);
        end

        // Advance the slot state on intake, dispatch and completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= SLOT_IDLE;
            end else begin
                unique case (state_q)
                    SLOT_IDLE:  if (arrive[k])       state_q <= SLOT_WAIT;
                    SLOT_WAIT:  if (dispatch_vec[k]) state_q <= SLOT_SERVE;
                    SLOT_SERVE: if (release_vec[k])  state_q <= SLOT_IDLE;
                    default:                         state_q <= SLOT_IDLE;
                endcase
            end
        end

        // Capture the request fields in the accepting cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q <= '0;
                pc_q   <= '0;
                sp_q   <= '0;
            end else if (arrive[k]) begin
                lock_q <= req_lock[k*LOCK_W +: LOCK_W];
                pc_q   <= req_pc[k*PC_W +: PC_W];
                sp_q   <= req_sp[k*SP_W +: SP_W];
            end
        end

        // Register the duplicate flag into a one-cycle error pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) dup_err[k] <= 1'b0;
            else        dup_err[k] <= dup_now;
        end

        assign slot_lock[k*LOCK_W +: LOCK_W] = lock_q;
        assign slot_pc[k*PC_W +: PC_W]       = pc_q;
        assign slot_sp[k*SP_W +: SP_W]       = sp_q;
    end

endmodule

// File: rtl/csq_age_order.sv
// Age matrix over the per-core slots.
// What it does: older_q[i*NC+j] set means slot i arrived before slot j.
// New arrivals are younger than every slot already stored. Arrivals in
// the same cycle are ordered by lower index first. The output is the
// one-hot oldest waiting slot.
// Assumes: a bit is only meaningful while both slots are waiting; stale
// bits are rewritten whenever either slot arrives again.
module csq_age_order #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] arrive,
    input  logic [NC-1:0] waiting,
    output logic [NC-1:0] oldest
);

    logic [NC*NC-1:0] older_q;

    for (genvar i = 0; i < NC; i++) begin : g_row
        for (genvar j = 0; j < NC; j++) begin : g_col
            localparam logic TIE_WIN = (i < j) ? 1'b1 : 1'b0;
            // Update the pair order whenever either member arrives.
            always_ff @(posedge clk) begin
                if (!rst_n || (i == j)) begin
                    older_q[i*NC+j] <= 1'b0;
                end else if (arrive[i] && arrive[j]) begin
                    older_q[i*NC+j] <= TIE_WIN;
                end else if (arrive[i]) begin
                    older_q[i*NC+j] <= 1'b0;
                end else if (arrive[j]) begin
                    older_q[i*NC+j] <= 1'b1;
                end
            end
        end
    end

    // A waiting slot is oldest when no other waiting slot is older.
    always_comb begin
        for (int i = 0; i < NC; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < NC; j++) begin
                if ((j != i) && waiting[j] && older_q[j*NC+i]) blocked = 1'b1;
            end
            oldest[i] = waiting[i] && !blocked;
        end
    end

endmodule

// File: rtl/csq_service.sv
// Service control for the large core.
// What it does: offers a request while nothing is in service, records
// which core was dispatched, accepts completion only while a request is
// in service and turns that completion into a one-cycle done pulse for
// the recorded core.
// Assumes: sel_id is the index of the oldest waiting slot whenever
// any_waiting is high.
module csq_service #(
    parameter int NC   = 4,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_waiting,
    input  logic [ID_W-1:0] sel_id,
    input  logic            disp_ready,
    input  logic            done_valid,
    output logic            disp_valid,
    output logic            done_ready,
    output logic            disp_fire,
    output logic [NC-1:0]   release_vec,
    output logic [NC-1:0]   core_done
);

    logic            busy_q;
    logic [ID_W-1:0] cur_q;
    logic            done_fire;

    // Offer and handshake decode.
    always_comb begin
        disp_valid = !busy_q && any_waiting;
        disp_fire  = disp_valid && disp_ready;
        done_ready = busy_q;
        done_fire  = done_valid && busy_q;
    end

    // One-hot release of the slot in service on completion.
    always_comb begin
        release_vec = '0;
        if (done_fire) release_vec[cur_q] = 1'b1;
    end

    // Track the single request in service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (done_fire) begin
            busy_q <= 1'b0;
        end else if (disp_fire) begin
            busy_q <= 1'b1;
            cur_q  <= sel_id;
        end
    end

    // Register the done pulse routed to the requesting core.
    always_ff @(posedge clk) begin
        if (!rst_n) core_done <= '0;
        else        core_done <= release_vec;
    end

endmodule

// File: rtl/csq_request_buffer.sv
// Critical section offload queue, top level.
// What it does: collects call requests from NC small cores, offers them in
// arrival order to one large core and routes each completion back to the
// core that made the request.
// Assumes: a core keeps its request fields valid in the cycle it raises
// req_valid; req_valid is sampled once per cycle and never back-pressured.
module csq_request_buffer #(
    parameter int NC     = 4,
    parameter int LOCK_W = 16,
    parameter int PC_W   = 16,
    parameter int SP_W   = 16,
    localparam int ID_W  = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NC-1:0]        req_valid,
    output logic [NC-1:0]        req_ready,
    input  logic [NC*LOCK_W-1:0] req_lock,
    input  logic [NC*PC_W-1:0]   req_pc,
    input  logic [NC*SP_W-1:0]   req_sp,
    output logic                 disp_valid,
    input  logic                 disp_ready,
    output logic [LOCK_W-1:0]    disp_lock,
    output logic [PC_W-1:0]      disp_pc,
    output logic [SP_W-1:0]      disp_sp,
    output logic [ID_W-1:0]      disp_core,
    input  logic                 done_valid,
    output logic                 done_ready,
    output logic [NC-1:0]        core_done,
    output logic [NC-1:0]        dup_err
);

    logic [NC-1:0]        arrive;
    logic [NC-1:0]        waiting;
    logic [NC-1:0]        oldest;
    logic [NC-1:0]        dispatch_vec;
    logic [NC-1:0]        release_vec;
    logic                 disp_fire;
    logic [NC*LOCK_W-1:0] slot_lock;
    logic [NC*PC_W-1:0]   slot_pc;
    logic [NC*SP_W-1:0]   slot_sp;
    logic [ID_W-1:0]      sel_id;

    // Every request is taken: it is either stored or dropped as a duplicate.
    assign req_ready = '1;

    csq_slot_file #(
        .NC(NC), .LOCK_W(LOCK_W), .PC_W(PC_W), .SP_W(SP_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp),
        .dispatch_vec(dispatch_vec), .release_vec(release_vec),
        .arrive(arrive), .waiting(waiting), .dup_err(dup_err),
        .slot_lock(slot_lock), .slot_pc(slot_pc), .slot_sp(slot_sp)
    );

    csq_age_order #(.NC(NC)) u_age (
        .clk(clk), .rst_n(rst_n),
        .arrive(arrive), .waiting(waiting), .oldest(oldest)
    );

    // Select the oldest slot's fields and index with an AND-OR mux.
    always_comb begin
        disp_lock = '0;
        disp_pc   = '0;
        disp_sp   = '0;
        sel_id    = '0;
        for (int k = 0; k < NC; k++) begin
            if (oldest[k]) begin
                disp_lock = disp_lock | slot_lock[k*LOCK_W +: LOCK_W];
                disp_pc   = disp_pc   | slot_pc[k*PC_W +: PC_W];
                disp_sp   = disp_sp   | slot_sp[k*SP_W +: SP_W];
                sel_id    = sel_id    | ID_W'(k);
            end
        end
    end

    assign disp_core    = sel_id;
    assign dispatch_vec = disp_fire ? oldest : '0;

    csq_service #(.NC(NC), .ID_W(ID_W)) u_service (
        .clk(clk), .rst_n(rst_n),
        .any_waiting(|waiting), .sel_id(sel_id),
        .disp_ready(disp_ready), .done_valid(done_valid),
        .disp_valid(disp_valid), .done_ready(done_ready),
        .disp_fire(disp_fire), .release_vec(release_vec),
        .core_done(core_done)
    );

endmodule

// File: rtl/csq_request_buffer_checker.sv
// Protocol checker for the offload queue, attached with bind.
// What it does: watches the top-level ports for the handshake, ordering
// and pulse rules of the requirements.
// Assumes: only port-level visibility.
module csq_request_buffer_checker #(
    parameter int NC   = 4,
    parameter int LW   = 16,
    parameter int IW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] req_valid,
    input logic          disp_valid,
    input logic          disp_ready,
    input logic [LW-1:0] disp_lock,
    input logic [IW-1:0] disp_core,
    input logic          done_valid,
    input logic          done_ready,
    input logic [NC-1:0] core_done,
    input logic [NC-1:0] dup_err
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!disp_valid && !done_ready && core_done == '0 && dup_err == '0));

    assert_single_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> !disp_valid);

    assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_core) && $stable(disp_lock)));

    assert_done_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_done));

    assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done != '0) |-> $past(done_valid && done_ready));

    assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> (core_done == '0));

    for (genvar k = 0; k < NC; k++) begin : g_dup
        assert_dup_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            dup_err[k] |-> $past(req_valid[k]));
    end

endmodule

bind csq_request_buffer csq_request_buffer_checker #(
    .NC(NC), .LW(LOCK_W), .IW(ID_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_lock(disp_lock), .disp_core(disp_core),
    .done_valid(done_valid), .done_ready(done_ready),
    .core_done(core_done), .dup_err(dup_err)
);

// File: tb/csq_request_buffer_test.sv
// Bench for the offload queue: directed corner cases plus seeded random
// traffic, compared every cycle against a reference queue kept here.
module csq_request_buffer_test;

    localparam int NC = 4;
    localparam int LW = 16;
    localparam int PW = 16;
    localparam int SW = 16;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_valid = '0;
    logic [NC-1:0]     req_ready;
    logic [NC*LW-1:0]  req_lock = '0;
    logic [NC*PW-1:0]  req_pc = '0;
    logic [NC*SW-1:0]  req_sp = '0;
    logic              disp_valid;
    logic              disp_ready = 1'b0;
    logic [LW-1:0]     disp_lock;
    logic [PW-1:0]     disp_pc;
    logic [SW-1:0]     disp_sp;
    logic [IW-1:0]     disp_core;
    logic              done_valid = 1'b0;
    logic              done_ready;
    logic [NC-1:0]     core_done;
    logic [NC-1:0]     dup_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state.
    int            q[$];
    bit            m_busy[NC];
    bit            m_inflight = 1'b0;
    int            m_cur = 0;
    logic [LW-1:0] m_lock[NC];
    logic [PW-1:0] m_pc[NC];
    logic [SW-1:0] m_sp[NC];
    logic [NC-1:0] exp_done = '0;
    logic [NC-1:0] exp_dup = '0;

    always #2ns clk = ~clk;

    csq_request_buffer #(.NC(NC), .LOCK_W(LW), .PC_W(PW), .SP_W(SW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_lock(disp_lock), .disp_pc(disp_pc), .disp_sp(disp_sp),
        .disp_core(disp_core),
        .done_valid(done_valid), .done_ready(done_ready),
        .core_done(core_done), .dup_err(dup_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_offer();
        return !m_inflight && (q.size() > 0);
    endfunction

    // Check outputs against the model, drive one cycle of inputs, update the
    // model and wait for the next negative edge.
    task automatic step(input logic [NC-1:0] rv, input bit dr, input bit dv);
        bit offer;
        bit nb[NC];
        offer = exp_offer();
        chk("R5", disp_valid, offer);
        if (offer) begin
            chk("R3", disp_core, q[0]);
            chk("R2", {disp_lock, disp_pc, disp_sp}, {m_lock[q[0]], m_pc[q[0]], m_sp[q[0]]});
        end
        chk("R6", core_done, exp_done);
        chk("R8", dup_err, exp_dup);
        chk("R9", req_ready, {NC{1'b1}});
        chk("R7", done_ready, m_inflight);
        req_valid  = rv;
        disp_ready = dr;
        done_valid = dv;
        for (int k = 0; k < NC; k++) begin
            req_lock[k*LW +: LW] = LW'($urandom);
            req_pc[k*PW +: PW]   = PW'($urandom);
            req_sp[k*SW +: SW]   = SW'($urandom);
        end
        nb = m_busy;
        exp_done = '0;
        exp_dup  = '0;
        for (int k = 0; k < NC; k++) begin
            if (rv[k]) begin
                if (m_busy[k]) begin
                    exp_dup[k] = 1'b1;
                end else begin
                    q.push_back(k);
                    nb[k] = 1'b1;
                    m_lock[k] = req_lock[k*LW +: LW];
                    m_pc[k]   = req_pc[k*PW +: PW];
                    m_sp[k]   = req_sp[k*SW +: SW];
                end
            end
        end
        if (dv && m_inflight) begin
            exp_done[m_cur] = 1'b1;
            nb[m_cur] = 1'b0;
            m_inflight = 1'b0;
        end else if (offer && dr) begin
            m_cur = q.pop_front();
            m_inflight = 1'b1;
        end
        m_busy = nb;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int n = 0; n < 24; n++) step('0, 1'b1, 1'b1);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h00C5_0FF1;
        void'($urandom(seed));
        for (int k = 0; k < NC; k++) begin
            m_busy[k] = 1'b0;
            m_lock[k] = '0; m_pc[k] = '0; m_sp[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet while held in reset.
        chk("R1", {disp_valid, done_ready, core_done, dup_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {disp_valid, done_ready, core_done, dup_err}, '0);

        // R4: all cores request at once; lowest index offered first.
        step('1, 1'b0, 1'b0);
        chk("R4", disp_core, 0);
        step('0, 1'b0, 1'b0);
        chk("R9", {disp_valid, disp_core}, {1'b1, 2'd0});
        drain();

        // R7: a completion with nothing in service is ignored.
        step('0, 1'b0, 1'b1);
        chk("R7", {core_done, disp_valid}, '0);
        step('0, 1'b0, 1'b0);
        chk("R7", core_done, '0);

        // R8: duplicate from core 2 while its first request waits.
        step(4'b0100, 1'b0, 1'b0);
        step(4'b0100, 1'b0, 1'b0);
        chk("R8", dup_err, 4'b0100);
        step(4'b0001, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        // R10: core 2 requests again in the cycle its done pulse shows.
        chk("R10", core_done, 4'b0100);
        step(4'b0100, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        step('0, 1'b0, 1'b0);
        chk("R10", {disp_valid, disp_core}, {1'b1, 2'd2});
        drain();

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [NC-1:0] rv;
            for (int k = 0; k < NC; k++) rv[k] = ($urandom % 4) == 0;
            step(rv, ($urandom % 2) == 0, m_inflight ? (($urandom % 3) == 0) : (($urandom % 10) == 0));
        end
        drain();
        chk("R3", q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule